// File: doc/BRIEF.md
# Pulse-Duration Remote-Control Transceiver

This block sends and captures pulse trains that are described as lists of durations, for infrared remote-control links. A local buffer holds 32-bit entries. Each entry carries two 16-bit duration fields. Each field holds a line level and a tick count. The transmitter walks through the fields in order and drives each level for its count of clock cycles. On fields whose level is high, it can gate the output with a carrier square wave, which gives on-off keying. A field with a zero count ends the list.

The receiver is armed by a start pulse and waits for the input to leave its idle level. It can first pass the input through a glitch filter. It then measures how long each level lasts and writes the lengths into the same buffer, in the same field format. A list captured this way can be replayed by the transmitter. Capture ends when the input stays at one level for a programmable number of cycles. Capture also ends when the buffer runs out of fields. A host port loads the buffer and reads it back.

Top module: `pulse_train_xcvr`

## Requirements
- R1: After reset, tx_out equals idle_level and tx_busy, tx_done, rx_busy, rx_done and rx_overflow are all 0.
- R2: A field is 16 bits: bit 15 is the line level and bits 14:0 are the tick count. Within an entry, bits 15:0 are sent before bits 31:16, and entries are sent in rising address order. When tx_start is taken while the transmitter is idle, each field drives its level on tx_out for exactly its count of cycles. The first field begins in the cycle that follows the accepting clock edge.
- R3: A field with a count of zero stops the transmitter. In the cycle after the last nonzero field, tx_busy is 0, tx_out equals idle_level and tx_done is 1. tx_done stays 1 until the next accepted tx_start.
- R4: When the last field of the last buffer entry has been sent, the transmitter stops in the same way as in R3, even though no zero field was found.
- R5: With carrier_en set, a level-1 field gives a waveform that is high for carrier_high cycles and then low for carrier_low cycles, repeating. This pattern restarts at the first cycle of every level-1 field. Level-0 fields drive 0. A carrier count of 0 behaves as 1.
- R6: tx_start has no effect while tx_busy is 1. The waveform in progress continues unchanged.
- R7: rx_start arms the receiver when it is idle. Capture begins once the input differs from idle_level. Each completed interval is written as one field, with its level in bit 15 and its length in cycles in bits 14:0, filling fields in the order of R2 from field 0.
- R8: When the input keeps one level for idle_thresh cycles (idle_thresh at least 2), the receiver writes a final field holding that level and a length of idle_thresh. It then writes zero into the next field, sets rx_done and drops rx_busy.
- R9: With filter_en set, an input change is taken only after the new value has held for filter_thresh consecutive cycles. Shorter pulses leave no trace in the captured fields. Longer intervals keep their length.
- R10: If an interval completes when no field is left, rx_overflow is set, rx_busy drops, rx_done stays 0 and the buffer is not written again.
- R11: With mem_wr_en set, a clock edge writes mem_wdata into entry mem_addr. mem_rdata always shows entry mem_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_wr_en | input | 1 | Host write strobe for the buffer |
| mem_addr | input | AW | Host entry address |
| mem_wdata | input | 32 | Host write data |
| mem_rdata | output | 32 | Entry at mem_addr |
| idle_level | input | 1 | Line level that means "no activity" |
| tx_start | input | 1 | Start sending from field 0 |
| carrier_en | input | 1 | Gate level-1 fields with the carrier |
| carrier_high | input | CW | Carrier high time in cycles |
| carrier_low | input | CW | Carrier low time in cycles |
| tx_out | output | 1 | Transmit line |
| tx_busy | output | 1 | Transmitter is walking a list |
| tx_done | output | 1 | Last list finished |
| rx_in | input | 1 | Receive line |
| rx_start | input | 1 | Arm a capture |
| filter_en | input | 1 | Enable the glitch filter |
| filter_thresh | input | FW | Minimum accepted pulse length in cycles |
| idle_thresh | input | 15 | Cycles without change that end a capture |
| rx_busy | output | 1 | Capture armed or running |
| rx_done | output | 1 | Capture ended by idle timeout |
| rx_overflow | output | 1 | Capture ended because the buffer was full |

## Verification
The assertions assume that the host does not write the buffer while a capture is writing it. They also assume that rx_in changes only between clock edges, and that idle_thresh is at least 2. The stimulus drives every input on the falling clock edge and uses the host port only while both engines are idle. Random durations are kept below the idle threshold so that only the final interval ends a capture. Data intervals alternate in level and end away from the idle level, so that no two intervals merge.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int LEN_W = 15;

  typedef struct packed {
    logic             lvl;
    logic [LEN_W-1:0] len;
  } ptx_field_t;

  typedef enum logic [1:0] {RX_IDLE, RX_ARMED, RX_RUN, RX_FINISH} rx_state_e;

  // Selects the half of an entry addressed by the low field-pointer bit.
  function automatic ptx_field_t pick_half(input logic [31:0] entry, input logic upper);
    return upper ? ptx_field_t'(entry[31:16]) : ptx_field_t'(entry[15:0]);
  endfunction

  // A programmed length of zero behaves as one cycle.
  function automatic logic [LEN_W-1:0] len_at_least_one(input logic [LEN_W-1:0] v);
    return (v == '0) ? LEN_W'(1) : v;
  endfunction
endpackage

// File: rtl/ptx_buffer.sv
module ptx_buffer #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic [AW-1:0] tx_addr,
  output logic [31:0]   tx_rdata,
  input  logic          cap_we,
  input  logic [AW-1:0] cap_addr,
  input  logic          cap_upper,
  input  logic [15:0]   cap_data
);
  logic [31:0] store_q [DEPTH];

  // Capture writes take priority over the host port.
  always_ff @(posedge clk) begin
    if (cap_we) begin
      if (cap_upper) store_q[cap_addr][31:16] <= cap_data;
      else           store_q[cap_addr][15:0]  <= cap_data;
    end else if (host_we) begin
      store_q[host_addr] <= host_wdata;
    end
  end

  assign host_rdata = store_q[host_addr];
  assign tx_rdata   = store_q[tx_addr];
endmodule

// File: rtl/ptx_carrier.sv
module ptx_carrier #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] high_len,
  input  logic [CW-1:0] low_len,
  output logic          phase
);
  logic [CW-1:0] left_q;

  function automatic logic [CW-1:0] floor_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 1'b1;
      left_q <= CW'(1);
    end else if (restart) begin
      phase  <= 1'b1;
      left_q <= floor_one(high_len);
    end else if (left_q <= CW'(1)) begin
      phase  <= ~phase;
      left_q <= phase ? floor_one(low_len) : floor_one(high_len);
    end else begin
      left_q <= left_q - CW'(1);
    end
  end
endmodule

// File: rtl/ptx_tx_engine.sv
module ptx_tx_engine
  import ptx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 2,
  localparam int FIELDS = 2 * DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          field_load,
  output logic          level,
  output logic          busy,
  output logic          done
);
  logic [PW-1:0]    ptr_q;
  logic [PW-1:0]    next_ptr;
  logic [LEN_W-1:0] left_q;
  ptx_field_t       next_fld;
  logic             advance;
  logic             stop_now;

  assign next_ptr   = busy ? ptr_q + PW'(1) : '0;
  assign rd_addr    = next_ptr[AW:1];
  assign next_fld   = pick_half(rd_data, next_ptr[0]);
  assign advance    = busy ? (left_q == LEN_W'(1)) : start;
  assign stop_now   = (next_ptr == PW'(FIELDS)) || (next_fld.len == '0);
  assign field_load = advance && !stop_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      left_q <= '0;
      level  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (advance) begin
      if (stop_now) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        busy   <= 1'b1;
        done   <= 1'b0;
        ptr_q  <= next_ptr;
        left_q <= next_fld.len;
        level  <= next_fld.lvl;
      end
    end else if (busy) begin
      left_q <= left_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/ptx_glitch_filter.sv
module ptx_glitch_filter #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          enable,
  input  logic [FW-1:0] thresh,
  output logic          dout
);
  logic [FW-1:0] run_q;
  logic [FW:0]   need;
  logic [FW:0]   run_next;

  assign need     = (!enable || thresh == '0) ? (FW+1)'(1) : {1'b0, thresh};
  assign run_next = {1'b0, run_q} + (FW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (din == dout) begin
      run_q <= '0;
    end else if (run_next >= need) begin
      dout  <= din;
      run_q <= '0;
    end else begin
      run_q <= run_next[FW-1:0];
    end
  end
endmodule

// File: rtl/ptx_rx_capture.sv
module ptx_rx_capture
  import ptx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 2,
  localparam int FIELDS = 2 * DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             line,
  input  logic             idle_level,
  input  logic [LEN_W-1:0] idle_thresh,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             wr_upper,
  output logic [15:0]      wr_data,
  output logic             busy,
  output logic             done,
  output logic             overflow
);
  rx_state_e        state_q;
  logic [PW-1:0]    ptr_q;
  logic             cur_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_inc;
  logic [LEN_W-1:0] limit;
  logic             emit_req;
  ptx_field_t       emit_val;
  logic             full;
  logic             timed_out;

  assign len_inc   = len_q + LEN_W'(1);
  assign limit     = len_at_least_one(idle_thresh);
  assign full      = (ptr_q == PW'(FIELDS));
  assign timed_out = (line == cur_q) && (len_inc >= limit);

  always_comb begin
    emit_req = 1'b0;
    emit_val = '0;
    case (state_q)
      RX_RUN: begin
        if (line != cur_q) begin
          emit_req = 1'b1;
          emit_val = '{lvl: cur_q, len: len_q};
        end else if (timed_out) begin
          emit_req = 1'b1;
          emit_val = '{lvl: cur_q, len: len_inc};
        end
      end
      RX_FINISH: emit_req = 1'b1;
      default: ;
    endcase
  end

  assign wr_en    = emit_req && !full;
  assign wr_addr  = ptr_q[AW:1];
  assign wr_upper = ptr_q[0];
  assign wr_data  = emit_val;
  assign busy     = (state_q != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      ptr_q    <= '0;
      cur_q    <= 1'b0;
      len_q    <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      case (state_q)
        RX_IDLE: if (start) begin
          state_q  <= RX_ARMED;
          ptr_q    <= '0;
          done     <= 1'b0;
          overflow <= 1'b0;
        end
        RX_ARMED: if (line != idle_level) begin
          state_q <= RX_RUN;
          cur_q   <= line;
          len_q   <= LEN_W'(1);
        end
        RX_RUN: begin
          if (emit_req && full) begin
            overflow <= 1'b1;
            state_q  <= RX_IDLE;
          end else if (line != cur_q) begin
            ptr_q <= ptr_q + PW'(1);
            cur_q <= line;
            len_q <= LEN_W'(1);
          end else if (timed_out) begin
            ptr_q   <= ptr_q + PW'(1);
            state_q <= RX_FINISH;
          end else begin
            len_q <= len_inc;
          end
        end
        RX_FINISH: begin
          if (!full) ptr_q <= ptr_q + PW'(1);
          done    <= 1'b1;
          state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_train_xcvr.sv
module pulse_train_xcvr #(
  parameter int DEPTH = 64,
  parameter int CW = 8,
  parameter int FW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_wdata,
  output logic [31:0]   mem_rdata,
  input  logic          idle_level,
  input  logic          tx_start,
  input  logic          carrier_en,
  input  logic [CW-1:0] carrier_high,
  input  logic [CW-1:0] carrier_low,
  output logic          tx_out,
  output logic          tx_busy,
  output logic          tx_done,
  input  logic          rx_in,
  input  logic          rx_start,
  input  logic          filter_en,
  input  logic [FW-1:0] filter_thresh,
  input  logic [14:0]   idle_thresh,
  output logic          rx_busy,
  output logic          rx_done,
  output logic          rx_overflow
);
  logic [AW-1:0] tx_rd_addr;
  logic [31:0]   tx_rd_data;
  logic          tx_field_load;
  logic          tx_lvl;
  logic          car_phase;
  logic          filt_line;
  logic          rx_wr_en;
  logic [AW-1:0] rx_wr_addr;
  logic          rx_wr_upper;
  logic [15:0]   rx_wr_data;

  ptx_buffer #(.DEPTH(DEPTH)) buf_i (
    .clk(clk), .host_we(mem_wr_en), .host_addr(mem_addr), .host_wdata(mem_wdata),
    .host_rdata(mem_rdata), .tx_addr(tx_rd_addr), .tx_rdata(tx_rd_data),
    .cap_we(rx_wr_en), .cap_addr(rx_wr_addr), .cap_upper(rx_wr_upper), .cap_data(rx_wr_data)
  );

  ptx_tx_engine #(.DEPTH(DEPTH)) tx_i (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .rd_addr(tx_rd_addr), .rd_data(tx_rd_data),
    .field_load(tx_field_load), .level(tx_lvl), .busy(tx_busy), .done(tx_done)
  );

  ptx_carrier #(.CW(CW)) car_i (
    .clk(clk), .rst_n(rst_n), .restart(tx_field_load), .high_len(carrier_high),
    .low_len(carrier_low), .phase(car_phase)
  );

  assign tx_out = tx_busy ? (tx_lvl & (~carrier_en | car_phase)) : idle_level;

  ptx_glitch_filter #(.FW(FW)) filt_i (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .enable(filter_en), .thresh(filter_thresh),
    .dout(filt_line)
  );

  ptx_rx_capture #(.DEPTH(DEPTH)) rx_i (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .line(filt_line), .idle_level(idle_level),
    .idle_thresh(idle_thresh), .wr_en(rx_wr_en), .wr_addr(rx_wr_addr),
    .wr_upper(rx_wr_upper), .wr_data(rx_wr_data), .busy(rx_busy), .done(rx_done),
    .overflow(rx_overflow)
  );
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_level,
  input logic          tx_start,
  input logic          carrier_en,
  input logic          tx_out,
  input logic          tx_busy,
  input logic          tx_done,
  input logic          tx_lvl,
  input logic          rx_busy,
  input logic          rx_done,
  input logic          rx_overflow,
  input logic          rx_wr_en,
  input logic [AW-1:0] rx_wr_addr,
  input logic          rx_wr_upper
);
  AST_TX_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_out == idle_level); // R3
  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_busy); // R3
  AST_TX_PLAIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && !carrier_en |-> tx_out == tx_lvl); // R2
  AST_TX_LOW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && !tx_lvl |-> !tx_out); // R5
  AST_TX_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy && tx_start |=> tx_busy || tx_done); // R2
  AST_RX_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_overflow)); // R10
  AST_RX_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> !rx_wr_en); // R10
  AST_RX_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_busy |-> !rx_wr_en); // R7
  AST_RX_FIELD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en && $past(rx_wr_en) |->
      {rx_wr_addr, rx_wr_upper} == $past({rx_wr_addr, rx_wr_upper}) + 1'b1); // R8
endmodule

bind pulse_train_xcvr ptx_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .idle_level(idle_level), .tx_start(tx_start),
  .carrier_en(carrier_en), .tx_out(tx_out), .tx_busy(tx_busy), .tx_done(tx_done),
  .tx_lvl(tx_lvl), .rx_busy(rx_busy), .rx_done(rx_done), .rx_overflow(rx_overflow),
  .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr), .rx_wr_upper(rx_wr_upper)
);

// File: tb/pulse_train_xcvr_tb.sv
module pulse_train_xcvr_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_wr_en = 0; logic [AW-1:0] mem_addr = '0; logic [31:0] mem_wdata = '0;
  logic [31:0] mem_rdata;
  logic idle_level = 0, tx_start = 0, carrier_en = 0;
  logic [7:0] carrier_high = 8'd1, carrier_low = 8'd1;
  logic tx_out, tx_busy, tx_done;
  logic rx_in = 0, rx_start = 0, filter_en = 0;
  logic [7:0] filter_thresh = 8'd1;
  logic [14:0] idle_thresh = 15'd20;
  logic rx_busy, rx_done, rx_overflow;

  int total = 0, bad = 0;
  logic [31:0] ent [0:DEPTH-1];
  bit expw [0:4095];

  always #(CLK_P/2) clk = ~clk;

  pulse_train_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .idle_level(idle_level),
    .tx_start(tx_start), .carrier_en(carrier_en), .carrier_high(carrier_high),
    .carrier_low(carrier_low), .tx_out(tx_out), .tx_busy(tx_busy), .tx_done(tx_done),
    .rx_in(rx_in), .rx_start(rx_start), .filter_en(filter_en),
    .filter_thresh(filter_thresh), .idle_thresh(idle_thresh), .rx_busy(rx_busy),
    .rx_done(rx_done), .rx_overflow(rx_overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk);
    mem_wr_en = 1'b1; mem_addr = a[AW-1:0]; mem_wdata = d;
    @(negedge clk);
    mem_wr_en = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [31:0] d);
    @(negedge clk);
    mem_addr = a[AW-1:0];
    #1 d = mem_rdata;
  endtask

  task automatic read_field(input int f, output logic [15:0] v);
    logic [31:0] e;
    host_read(f / 2, e);
    v = (f % 2) ? e[31:16] : e[15:0];
  endtask

  // Expected transmit waveform, one bit per cycle after the start edge.
  task automatic build_tx_exp(output int n);
    int hh, ll;
    hh = (carrier_high == 0) ? 1 : int'(carrier_high);
    ll = (carrier_low == 0) ? 1 : int'(carrier_low);
    n = 0;
    for (int f = 0; f < 2 * DEPTH; f++) begin
      logic [15:0] fld;
      fld = (f % 2) ? ent[f/2][31:16] : ent[f/2][15:0];
      if (fld[14:0] == 0) break;
      for (int k = 0; k < int'(fld[14:0]); k++) begin
        expw[n] = fld[15] && (!carrier_en || (k % (hh + ll)) < hh);
        n++;
      end
    end
  endtask

  task automatic run_tx(input int nwr, input bit poke_mid, input string req);
    int n, miss, first;
    logic got;
    for (int i = 0; i < nwr; i++) host_write(i, ent[i]);
    build_tx_exp(n);
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    miss = 0; first = -1; got = 1'b0;
    for (int k = 0; k < n; k++) begin
      tx_start = (poke_mid && k == 2) ? 1'b1 : 1'b0;
      if (tx_out !== expw[k] || tx_busy !== 1'b1) begin
        if (first < 0) begin first = k; got = tx_out; end
        miss++;
      end
      @(negedge clk);
    end
    tx_start = 1'b0;
    check(miss == 0, req, $sformatf("waveform cycle %0d", first), {31'd0, got},
          {31'd0, (first >= 0) ? expw[first] : 1'b0});
    check(tx_done === 1'b1 && tx_busy === 1'b0 && tx_out === idle_level, "R3",
          "end of list state", {29'd0, tx_done, tx_busy, tx_out}, {29'd0, 1'b1, 1'b0, idle_level});
  endtask

  task automatic drive(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_arm();
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
  endtask

  task automatic check_field(input int f, input logic [15:0] exp, input string req);
    logic [15:0] v;
    read_field(f, v);
    check(v === exp, req, $sformatf("field %0d", f), {16'd0, v}, {16'd0, exp});
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lens [0:15];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_out === idle_level && !tx_busy && !tx_done, "R1", "tx reset",
          {29'd0, tx_out, tx_busy, tx_done}, {29'd0, idle_level, 2'b00});
    check(!rx_busy && !rx_done && !rx_overflow, "R1", "rx reset",
          {29'd0, rx_busy, rx_done, rx_overflow}, 32'd0);

    // R11 host port
    host_write(5, 32'hA5C3_1234);
    host_read(5, rd);
    check(rd === 32'hA5C3_1234, "R11", "host readback", rd, 32'hA5C3_1234);

    // R3 empty list: first field zero
    ent[0] = 32'h0;
    run_tx(1, 1'b0, "R3");

    // R2, R5, R6 random lists
    for (int r = 0; r < 6; r++) begin
      int nent;
      idle_level   = 1'($urandom % 2);
      carrier_en   = (r >= 2) ? 1'($urandom % 2) | (r == 3) : 1'b0;
      carrier_high = 8'($urandom % 4);
      carrier_low  = 8'($urandom % 4);
      nent = 2 + $urandom % 5;
      for (int i = 0; i < nent; i++)
        ent[i] = {1'($urandom % 2), 15'(1 + $urandom % 12), 1'($urandom % 2), 15'(1 + $urandom % 12)};
      ent[nent] = 32'h0;
      if ($urandom % 3 == 0) ent[nent-1][31:16] = 16'h0;
      run_tx(nent + 1, r == 1, carrier_en ? "R5" : (r == 1 ? "R6" : "R2"));
    end

    // R5 directed: carrier with zero counts behaves as 1/1
    idle_level = 1'b0; carrier_en = 1'b1; carrier_high = 8'd0; carrier_low = 8'd0;
    ent[0] = {1'b1, 15'd5, 1'b1, 15'd4}; ent[1] = 32'h0;
    run_tx(2, 1'b0, "R5");

    // R4 full buffer with no zero field
    carrier_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) ent[i] = {1'b0, 15'd1, 1'b1, 15'd1};
    run_tx(DEPTH, 1'b0, "R4");

    // R7, R8 random captures
    for (int r = 0; r < 3; r++) begin
      int n;
      logic lv;
      filter_en = 1'b0; idle_thresh = 15'd20;
      idle_level = 1'(r % 2);
      for (int i = 0; i < 10; i++) host_write(i, 32'hFFFF_FFFF);
      rx_in = idle_level;
      repeat (3) @(negedge clk);
      rx_arm();
      n = 3 + 2 * ($urandom % 3);
      for (int i = 0; i < n; i++) begin
        lens[i] = 1 + $urandom % 15;
        lv = (i % 2 == 0) ? ~idle_level : idle_level;
        drive(lv, lens[i]);
      end
      drive(idle_level, 30);
      check(rx_done && !rx_overflow && !rx_busy, "R8", "capture end flags",
            {29'd0, rx_done, rx_overflow, rx_busy}, 32'd4);
      for (int i = 0; i < n; i++)
        check_field(i, {(i % 2 == 0) ? ~idle_level : idle_level, 15'(lens[i])}, "R7");
      check_field(n, {idle_level, 15'd20}, "R8");
      check_field(n + 1, 16'h0, "R8");
    end

    // R9 glitch filter
    idle_level = 1'b0; filter_en = 1'b1; filter_thresh = 8'd4; idle_thresh = 15'd20;
    for (int i = 0; i < 4; i++) host_write(i, 32'hFFFF_FFFF);
    rx_in = 1'b0;
    repeat (3) @(negedge clk);
    rx_arm();
    drive(0, 5); drive(1, 2); drive(0, 6);
    drive(1, 4); drive(0, 2); drive(1, 4);
    drive(0, 7); drive(1, 5); drive(0, 40);
    check(rx_done === 1'b1, "R9", "filtered capture done", {31'd0, rx_done}, 32'd1);
    check_field(0, {1'b1, 15'd10}, "R9");
    check_field(1, {1'b0, 15'd7}, "R9");
    check_field(2, {1'b1, 15'd5}, "R9");
    check_field(3, {1'b0, 15'd20}, "R9");
    check_field(4, 16'h0, "R9");

    // R10 overflow
    filter_en = 1'b0;
    rx_in = 1'b0;
    repeat (3) @(negedge clk);
    rx_arm();
    for (int i = 0; i < 2 * DEPTH + 4; i++) drive((i % 2 == 0) ? 1'b1 : 1'b0, 2);
    drive(0, 30);
    check(rx_overflow && !rx_done && !rx_busy, "R10", "overflow flags",
          {29'd0, rx_overflow, rx_done, rx_busy}, 32'd4);
    host_read(DEPTH - 1, rd);
    check(rd === 32'h0002_8002, "R10", "last entry", rd, 32'h0002_8002);
    host_read(0, rd);
    check(rd === 32'h0002_8002, "R10", "first entry kept", rd, 32'h0002_8002);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule